// File: doc/BRIEF.md
# Programmable Instruction Bit Permuter

This block is placed in series between the fetch stage and the decode stage of a 32-bit soft processor. Each device stores its program with the bits of every instruction word shuffled in its own way. The permuter undoes that shuffle before decode. Every output bit has its own multiplexer, and that multiplexer can pick any input bit. The choice for each output bit comes from a 5-bit field in a run-time loadable select store, so any transposition can be installed without rebuilding the logic. After the permutation, an optional 32-bit constant can be XORed onto the word to add freedom.

Configuration is written one 32-bit word at a time through a small write port. Word indices 0 to 4 fill the select store, and index 5 holds the XOR constant. The path from instruction input to instruction output is combinational by default, and the valid signal travels alongside the word. A parameter adds one register stage on the output. A flag reports when the installed selects are not a true permutation.

Top module: `insn_bit_permuter`

## Requirements
- R1: Reset state. While `rst_n` is low and after it is released, select field k holds the value k and the XOR constant is zero. Each instruction word therefore appears unchanged at `out_word`, and `cfg_err` is 0.
- R2: Bit selection. All select words placed side by side form one vector, with word i at vector bits [32i+31:32i]. Field k occupies vector bits [5k+4:5k]. Output bit k equals input bit number field k, before the XOR constant is applied.
- R3: With the default parameters, `out_valid` equals `in_valid` in the same cycle, and `out_word` follows `in_word` with no clock edge in between.
- R4: A write with `cfg_we` high and `cfg_idx` from 0 to 4 replaces select word `cfg_idx` with `cfg_wdata`. The output uses the old mapping until the rising clock edge that samples the write, and the new mapping from that edge onward.
- R5: A write to index 5 loads the XOR constant. From the next edge onward, `out_word` equals the permuted word XOR the constant.
- R6: Writes to index 6 or 7 change neither the mapping nor the XOR constant.
- R7: `cfg_err` is 1 exactly when two select fields name the same input bit, which means the fields do not form a permutation of 0 to 31. It returns to 0 once a true permutation is installed again.
- R8: While `cfg_we` is low, changes on `cfg_idx` and `cfg_wdata` have no effect on the stored configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 32 | Shuffled instruction word from fetch |
| in_valid | input | 1 | Qualifies `in_word` |
| out_word | output | 32 | Restored instruction word to decode |
| out_valid | output | 1 | Qualifies `out_word` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration word index (0 to 4 selects, 5 XOR constant) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_err | output | 1 | Installed selects are not a permutation |

## Verification
The embedded properties check the following on every cycle:
- The select store and the XOR constant hold still when no write is addressed to them, which covers R6 and R8.
- An addressed select word takes the written data at the next edge, which covers R4.
- Whenever the flag is clear and the constant is zero, the output carries exactly as many ones as the input, which ties R2 to R7.

Other properties need the bench scenarios:
- The exact bit placement for many different permutations, checked with walking-one sweeps.
- The moment a new mapping becomes visible, relative to the clock edge.
- The duplicate-field flag rising and falling.
- The XOR constant's effect on the output.

// File: rtl/perm_pkg.sv
package perm_pkg;

   // Number of configuration words needed to hold a packed vector of bits.
   function automatic int unsigned words_for(int unsigned bits, int unsigned word_w);
      return (bits + word_w - 1) / word_w;
   endfunction

   // Identity select vector: field k holds the value k.
   function automatic logic [1023:0] identity_sel(int unsigned n, int unsigned fw);
      logic [1023:0] v;
      v = '0;
      for (int unsigned k = 0; k < n; k++) begin
         for (int unsigned b = 0; b < fw; b++) begin
            v[k*fw + b] = k[b];
         end
      end
      return v;
   endfunction

endpackage

// File: rtl/perm_cfg_regs.sv
module perm_cfg_regs
   import perm_pkg::*;
#(
   parameter int W      = 32,
   parameter int SELW   = 5,
   parameter int CFG_W  = 32,
   parameter bit XOR_EN = 1'b1,
   parameter int NSEL   = 5,
   parameter int IDXW   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [IDXW-1:0]         cfg_idx,
   input  logic [CFG_W-1:0]        cfg_wdata,
   output logic [NSEL*CFG_W-1:0]   sel_o,
   output logic [W-1:0]            xor_o
);

   localparam int                  SELBITS = NSEL * CFG_W;
   localparam logic [1023:0]       IDENT_WIDE = identity_sel(W, SELW);
   localparam logic [SELBITS-1:0]  IDENT = IDENT_WIDE[SELBITS-1:0];
   localparam logic [IDXW-1:0]     XIDX = IDXW'(NSEL);

   logic [CFG_W-1:0] word_q [NSEL];

   for (genvar i = 0; i < NSEL; i++) begin : g_word
      localparam logic [CFG_W-1:0] RST_VAL = IDENT[i*CFG_W +: CFG_W];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q[i] <= RST_VAL;
         end else if (cfg_we && cfg_idx == IDXW'(i)) begin
            word_q[i] <= cfg_wdata;
         end
      end
      assign sel_o[i*CFG_W +: CFG_W] = word_q[i];
   end

   if (XOR_EN) begin : g_xor
      logic [W-1:0] xor_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            xor_q <= '0;
         end else if (cfg_we && cfg_idx == XIDX) begin
            xor_q <= cfg_wdata[W-1:0];
         end
      end
      assign xor_o = xor_q;
   end else begin : g_no_xor
      assign xor_o = '0;
   end

   // R6 R8
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && (int'(cfg_idx) < NSEL)) |=> $stable(sel_o));

   // R4
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_idx) < NSEL)) |=>
         sel_o[int'($past(cfg_idx))*CFG_W +: CFG_W] == $past(cfg_wdata));

   // R5 R6 R8
   xor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_idx == XIDX) |=> $stable(xor_o));

endmodule

// File: rtl/perm_mux_array.sv
module perm_mux_array #(
   parameter int W    = 32,
   parameter int SELW = 5
) (
   input  logic [W-1:0]      in_word,
   input  logic [W*SELW-1:0] sel_vec,
   output logic [W-1:0]      out_word
);

   // One W-to-1 multiplexer per output bit.
   for (genvar k = 0; k < W; k++) begin : g_mux
      logic [SELW-1:0] pick;
      assign pick        = sel_vec[k*SELW +: SELW];
      assign out_word[k] = in_word[pick];
   end

endmodule

// File: rtl/perm_dup_detect.sv
module perm_dup_detect #(
   parameter int W    = 32,
   parameter int SELW = 5
) (
   input  logic [W*SELW-1:0] sel_vec,
   output logic              not_perm
);

   logic [W-1:0] used;

   // With W fields over W positions, a missing position implies a repeat.
   always_comb begin
      used = '0;
      for (int k = 0; k < W; k++) begin
         used[sel_vec[k*SELW +: SELW]] = 1'b1;
      end
   end

   assign not_perm = ~&used;

endmodule

// File: rtl/insn_bit_permuter.sv
module insn_bit_permuter
   import perm_pkg::*;
#(
   parameter int W       = 32,
   parameter int CFG_W   = 32,
   parameter bit XOR_EN  = 1'b1,
   parameter bit PIPE_EN = 1'b0,
   localparam int SELW   = $clog2(W),
   localparam int NSEL   = words_for(W * SELW, CFG_W),
   localparam int IDXW   = $clog2(NSEL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     in_word,
   input  logic             in_valid,
   output logic [W-1:0]     out_word,
   output logic             out_valid,
   input  logic             cfg_we,
   input  logic [IDXW-1:0]  cfg_idx,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             cfg_err
);

   if ((1 << SELW) != W) begin : g_bad_width
      $error("insn_bit_permuter: W must be a power of two");
   end
   if (CFG_W < W) begin : g_bad_cfg
      $error("insn_bit_permuter: CFG_W must cover the XOR constant");
   end
   if (W * SELW > 1024) begin : g_too_big
      $error("insn_bit_permuter: select vector exceeds identity table size");
   end

   logic [NSEL*CFG_W-1:0] sel_store;
   logic [W*SELW-1:0]     sel_vec;
   logic [W-1:0]          xor_k;
   logic [W-1:0]          perm_word;
   logic [W-1:0]          mixed_word;

   perm_cfg_regs #(
      .W(W), .SELW(SELW), .CFG_W(CFG_W), .XOR_EN(XOR_EN),
      .NSEL(NSEL), .IDXW(IDXW)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_idx  (cfg_idx),
      .cfg_wdata(cfg_wdata),
      .sel_o    (sel_store),
      .xor_o    (xor_k)
   );

   assign sel_vec = sel_store[W*SELW-1:0];

   perm_mux_array #(.W(W), .SELW(SELW)) u_mux (
      .in_word (in_word),
      .sel_vec (sel_vec),
      .out_word(perm_word)
   );

   perm_dup_detect #(.W(W), .SELW(SELW)) u_dup (
      .sel_vec (sel_vec),
      .not_perm(cfg_err)
   );

   assign mixed_word = perm_word ^ xor_k;

   if (PIPE_EN) begin : g_pipe
      logic [W-1:0] word_q;
      logic         valid_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
         end else begin
            word_q  <= mixed_word;
            valid_q <= in_valid;
         end
      end
      assign out_word  = word_q;
      assign out_valid = valid_q;
   end else begin : g_comb
      assign out_word  = mixed_word;
      assign out_valid = in_valid;
   end

   // R2 R7
   ones_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_err && xor_k == '0) |-> $countones(perm_word) == $countones(in_word));

   // R1
   reset_ident_chk: assert property (@(posedge clk)
      !rst_n |=> (perm_word == $past(in_word) || $changed(in_word)) && xor_k == '0);

endmodule

// File: tb/insn_bit_permuter_bench.sv
module insn_bit_permuter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_valid = 1'b0;
   logic [31:0] out_word;
   logic        out_valid;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_err;

   int checks = 0;
   int errors = 0;
   int sel_m [32];
   logic [31:0] xor_m = '0;

   always #2 clk = ~clk;

   insn_bit_permuter u_insn_bit_permuter (
      .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
      .out_word(out_word), .out_valid(out_valid), .cfg_we(cfg_we),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err)
   );

   function automatic logic [31:0] model(logic [31:0] w);
      logic [31:0] r;
      for (int k = 0; k < 32; k++) r[k] = w[sel_m[k]];
      return r ^ xor_m;
   endfunction

   function automatic logic [159:0] packed_sel();
      logic [159:0] p;
      p = '0;
      for (int k = 0; k < 32; k++) p[k*5 +: 5] = 5'(sel_m[k]);
      return p;
   endfunction

   function automatic logic model_err();
      logic [31:0] u;
      u = '0;
      for (int k = 0; k < 32; k++) u[sel_m[k]] = 1'b1;
      return ~&u;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(logic [2:0] idx, logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_sel();
      logic [159:0] p;
      p = packed_sel();
      for (int i = 0; i < 5; i++) cfg_write(3'(i), p[i*32 +: 32]);
   endtask

   task automatic sweep(string req);
      for (int b = 0; b < 32; b++) begin
         in_word = 32'h1 << b;
         #1 check(req, out_word, model(in_word));
      end
      foreach (sel_m[j]) begin
         if (j < 4) begin
            in_word = 32'hA5C3_0F96 ^ (32'h1357_9BDF * j);
            #1 check(req, out_word, model(in_word));
         end
      end
      check({req, " flag"}, {31'b0, cfg_err}, {31'b0, model_err()});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 32; k++) sel_m[k] = k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: identity pass-through after reset
      sweep("R1");

      // R3: valid passes straight through, word follows with no edge
      in_valid = 1'b1; #1 check("R3", {31'b0, out_valid}, 32'd1);
      in_valid = 1'b0; #1 check("R3", {31'b0, out_valid}, 32'd0);
      in_word = 32'hDEAD_BEEF; #1 check("R3", out_word, 32'hDEAD_BEEF);

      // R2: rotations
      foreach (sel_m[j]) begin
         if (j == 1 || j == 5 || j == 17) begin
            for (int k = 0; k < 32; k++) sel_m[k] = (k + j) % 32;
            load_sel();
            sweep("R2");
         end
      end
      // R2: reversal
      for (int k = 0; k < 32; k++) sel_m[k] = 31 - k;
      load_sel();
      sweep("R2");
      // R2: odd multipliers
      foreach (sel_m[j]) begin
         if (j == 3 || j == 7 || j == 13) begin
            for (int k = 0; k < 32; k++) sel_m[k] = (k * j) % 32;
            load_sel();
            sweep("R2");
         end
      end

      // R4: old mapping until the sampling edge, new mapping after it
      begin
         logic [159:0] p;
         int t;
         @(negedge clk);
         in_word = 32'h0000_0001;
         t = sel_m[0]; sel_m[0] = sel_m[1]; sel_m[1] = t;
         p = packed_sel();
         t = sel_m[0]; sel_m[0] = sel_m[1]; sel_m[1] = t;
         cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = p[31:0];
         in_word = 32'h1 << sel_m[0];
         #1 check("R4 before edge", out_word, model(in_word));
         @(posedge clk);
         t = sel_m[0]; sel_m[0] = sel_m[1]; sel_m[1] = t;
         #1 check("R4 after edge", out_word, model(in_word));
         @(negedge clk);
         cfg_we = 1'b0;
         sweep("R4");
      end

      // R5: XOR constant
      xor_m = 32'h5A5A_F00F;
      cfg_write(3'd5, xor_m);
      sweep("R5");

      // R6: unused indices
      cfg_write(3'd6, 32'hFFFF_FFFF);
      cfg_write(3'd7, 32'h0000_0000);
      sweep("R6");

      // R8: strobe low, address and data wiggle
      @(negedge clk);
      cfg_idx = 3'd0; cfg_wdata = 32'h0;
      @(negedge clk);
      cfg_idx = 3'd5; cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      sweep("R8");

      // R7: duplicate field flags an error, restoring clears it
      xor_m = '0;
      cfg_write(3'd5, 32'h0);
      for (int k = 0; k < 32; k++) sel_m[k] = k;
      sel_m[4] = 3;
      load_sel();
      check("R7 set", {31'b0, cfg_err}, 32'd1);
      sweep("R7");
      sel_m[4] = 4;
      load_sel();
      check("R7 clear", {31'b0, cfg_err}, 32'd0);
      sweep("R7");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule